// File: doc/BRIEF.md
# Radio interrupt status controller

This block gathers one-cycle event pulses from a packet radio core (transmit finished, frame received, decryption pending) into a sticky status byte. A companion control byte can silence each source. One external interrupt line is driven whenever an event is latched whose source has not been silenced. The level that line takes when active is chosen by a bit in a separate configuration register.

Host access is a simple register strobe interface with a 6-bit address and 8-bit data. Reading the status address empties the status byte as a side effect, so the host reads once and gets every latched event. An event that arrives in the cycle of that read is not lost. The status byte, the control byte and the pin are all registered and change on the same clock edge.

Top module: `radio_irq_ctrl`

## Requirements
- R1: A strobe on `ev_tx_done`, `ev_rx_done` or `ev_sec_pend` sets status bit 0, 3 or 4 respectively on the following edge. The bit stays set until the status is read.
- R2: Status bits 1, 2, 5, 6 and 7 and control bits in those same positions always read 0, even after the control byte is written with 0xFF.
- R3: A read strobe at address 0x31 clears every status bit on the next edge.
- R4: An event strobe in the same cycle as a status read leaves that event's bit set after the clear.
- R5: Control bits share the status bit positions, and a 1 silences that source. After reset the control byte is 0x19, so every source starts silenced. The control byte is written at address 0x32.
- R6: The pin is active exactly while some status bit is set whose control bit is 0. It updates on the same edge as the status and control bytes.
- R7: Bit 1 of the configuration register at address 0x3A selects the pin polarity: 0 (reset) means active-low, 1 means active-high.
- R8: A write to the status address has no effect, and a read at any other address does not clear the status.
- R9: During and after reset the status byte is 0 and the pin is high, because the pin is inactive and the polarity is active-low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_tx_done | input | 1 | Transmit-complete event pulse |
| ev_rx_done | input | 1 | Receive-complete event pulse |
| ev_sec_pend | input | 1 | Decryption-pending event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 8 | Write data |
| status_q | output | 8 | Current status byte |
| ctrl_q | output | 8 | Current control byte |
| irq_pin | output | 1 | Interrupt pin at the selected level |

## Verification
The bench builds the block with its default parameters: 6-bit addresses, the three sources at bits 0, 3 and 4, and the polarity bit at position 1. These defaults put every corner within reach: reads that collide with events, each silencing combination, a control write carrying 0xFF, and both pin levels. The bench also reaches writes and reads at addresses that must leave the status untouched.

// File: rtl/rirq_pkg.sv
package rirq_pkg;
  localparam int NSRC   = 3;
  localparam int STAT_W = 8;

  // bit position of each source inside status and control
  function automatic int src_bit(input int idx);
    case (idx)
      0:       return 0;
      1:       return 3;
      default: return 4;
    endcase
  endfunction

  function automatic logic [STAT_W-1:0] src_mask();
    logic [STAT_W-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rirq_event_latch.sv
module rirq_event_latch #(
  parameter int NSRC = rirq_pkg::NSRC,
  parameter int W    = rirq_pkg::STAT_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] ev,
  input  logic            rd_clr,
  output logic [W-1:0]    stat_d,
  output logic [W-1:0]    stat_q
);
  always_comb begin
    stat_d = '0;
    for (int i = 0; i < NSRC; i++)
      stat_d[rirq_pkg::src_bit(i)] = ev[i] | (stat_q[rirq_pkg::src_bit(i)] & ~rd_clr);
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src_chk
    localparam int P = rirq_pkg::src_bit(g);
    // R1
    event_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
      ev[g] |=> stat_q[P]);
    // R4
    read_keeps_event_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && ev[g]) |=> stat_q[P]);
  end

  // R3
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && ev == '0) |=> (stat_q == '0));
  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/rirq_regs.sv
module rirq_regs #(
  parameter int              ADDR_W    = 6,
  parameter int              W         = rirq_pkg::STAT_W,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h32,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 6'h3A,
  parameter int              POL_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      ctrl_d,
  output logic [W-1:0]      ctrl_q,
  output logic              pol_d,
  output logic              pol_q
);
  localparam logic [W-1:0] MASK = rirq_pkg::src_mask();

  always_comb begin
    ctrl_d = ctrl_q;
    pol_d  = pol_q;
    if (wr && addr == CTRL_ADDR) ctrl_d = wdata & MASK;
    if (wr && addr == CFG_ADDR)  pol_d  = wdata[POL_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= MASK;
      pol_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pol_q  <= pol_d;
    end
  end

  // R2
  ctrl_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q & ~MASK) == '0);
endmodule

// File: rtl/rirq_pin_drive.sv
module rirq_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic act_d,
  input  logic pol_d,
  output logic pin_q
);
  always_ff @(posedge clk) begin
    if (rst) pin_q <= 1'b1;
    else     pin_q <= ~(act_d ^ pol_d);
  end
endmodule

// File: rtl/radio_irq_ctrl.sv
module radio_irq_ctrl #(
  parameter int                ADDR_W    = 6,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 6'h31,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 6'h32,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 6'h3A,
  parameter int                POL_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_tx_done,
  input  logic              ev_rx_done,
  input  logic              ev_sec_pend,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        status_q,
  output logic [7:0]        ctrl_q,
  output logic              irq_pin
);
  localparam int NSRC = rirq_pkg::NSRC;
  localparam int W    = rirq_pkg::STAT_W;
  localparam logic [W-1:0] MASK = rirq_pkg::src_mask();

  logic [NSRC-1:0] ev;
  logic [W-1:0]    stat_d, ctrl_d;
  logic            pol_d, pol_q, rd_clr, act_d;

  assign ev     = {ev_sec_pend, ev_rx_done, ev_tx_done};
  assign rd_clr = reg_rd && (reg_addr == STAT_ADDR);
  assign act_d  = |(stat_d & ~ctrl_d);

  rirq_event_latch #(.NSRC(NSRC), .W(W)) u_latch (
    .clk(clk), .rst(rst), .ev(ev), .rd_clr(rd_clr),
    .stat_d(stat_d), .stat_q(status_q)
  );

  rirq_regs #(.ADDR_W(ADDR_W), .W(W), .CTRL_ADDR(CTRL_ADDR),
              .CFG_ADDR(CFG_ADDR), .POL_BIT(POL_BIT)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .ctrl_d(ctrl_d), .ctrl_q(ctrl_q), .pol_d(pol_d), .pol_q(pol_q)
  );

  rirq_pin_drive u_pin (
    .clk(clk), .rst(rst), .act_d(act_d), .pol_d(pol_d), .pin_q(irq_pin)
  );

  // R6
  pin_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pin == ~((|(status_q & ~ctrl_q)) ^ pol_q));
  // R2
  stat_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q & ~MASK) == '0);
endmodule

// File: tb/radio_irq_ctrl_test.sv
module radio_irq_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic ev_tx = 1'b0, ev_rx = 1'b0, ev_sec = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] status_q, ctrl_q;
  logic irq_pin;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  radio_irq_ctrl uut (
    .clk(clk), .rst(rst), .ev_tx_done(ev_tx), .ev_rx_done(ev_rx),
    .ev_sec_pend(ev_sec), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_q(status_q), .ctrl_q(ctrl_q), .irq_pin(irq_pin)
  );

  // {sec, rx, tx, status read, expected status}
  localparam logic [11:0] VEC [9] = '{
    {3'b001, 1'b0, 8'h01},  // R1 tx
    {3'b010, 1'b0, 8'h09},  // R1 rx, tx held
    {3'b000, 1'b1, 8'h00},  // R3 clear
    {3'b100, 1'b1, 8'h10},  // R4 sec during read
    {3'b000, 1'b0, 8'h10},  // R1 held
    {3'b000, 1'b1, 8'h00},  // R3
    {3'b111, 1'b0, 8'h19},  // R1 all
    {3'b001, 1'b1, 8'h01},  // R4 tx during read
    {3'b000, 1'b1, 8'h00}   // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick(input logic [2:0] ev, input logic rd, input logic wr,
                      input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    {ev_sec, ev_rx, ev_tx} = ev;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #2;
    {ev_sec, ev_rx, ev_tx} = 3'b000;
    reg_rd = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R9 status in reset", status_q, 8'h00);
    chk("R9 pin in reset", {7'd0, irq_pin}, 8'h01);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R5 ctrl reset", ctrl_q, 8'h19);
    chk("R9 pin after reset", {7'd0, irq_pin}, 8'h01);

    // all silenced: event latches but pin stays inactive
    tick(3'b001, 0, 0, 6'h00, 8'h00);
    chk("R5 silenced status", status_q, 8'h01);
    chk("R5 silenced pin", {7'd0, irq_pin}, 8'h01);
    tick(3'b000, 1, 0, 6'h31, 8'h00);
    chk("R3 clear", status_q, 8'h00);

    tick(3'b000, 0, 1, 6'h32, 8'h00);
    chk("R5 ctrl write", ctrl_q, 8'h00);
    for (int i = 0; i < 9; i++) begin
      tick(VEC[i][11:9], VEC[i][8], 0, VEC[i][8] ? 6'h31 : 6'h00, 8'h00);
      chk("R1/R3/R4 table status", status_q, VEC[i][7:0]);
      chk("R6 table pin", {7'd0, irq_pin}, (VEC[i][7:0] != 8'h00) ? 8'h00 : 8'h01);
    end

    // rx silenced
    tick(3'b000, 0, 1, 6'h32, 8'h08);
    tick(3'b010, 0, 0, 6'h00, 8'h00);
    chk("R5 rx silenced status", status_q, 8'h08);
    chk("R5 rx silenced pin", {7'd0, irq_pin}, 8'h01);
    tick(3'b001, 0, 0, 6'h00, 8'h00);
    chk("R6 tx enabled status", status_q, 8'h09);
    chk("R6 tx enabled pin", {7'd0, irq_pin}, 8'h00);
    tick(3'b000, 0, 1, 6'h32, 8'h19);
    chk("R6 pin after silencing all", {7'd0, irq_pin}, 8'h01);
    tick(3'b000, 0, 1, 6'h32, 8'h08);
    chk("R6 pin after re-enable", {7'd0, irq_pin}, 8'h00);
    tick(3'b000, 1, 0, 6'h31, 8'h00);
    chk("R3 clear status", status_q, 8'h00);
    chk("R3 clear pin", {7'd0, irq_pin}, 8'h01);

    tick(3'b000, 0, 1, 6'h32, 8'hFF);
    chk("R2 ctrl unused bits", ctrl_q, 8'h19);
    tick(3'b000, 0, 1, 6'h32, 8'h00);

    tick(3'b100, 0, 0, 6'h00, 8'h00);
    tick(3'b000, 0, 1, 6'h31, 8'hFF);
    chk("R8 write to status ignored", status_q, 8'h10);
    tick(3'b000, 1, 0, 6'h32, 8'h00);
    chk("R8 other read keeps status", status_q, 8'h10);
    chk("R8 pin active", {7'd0, irq_pin}, 8'h00);

    tick(3'b000, 0, 1, 6'h3A, 8'h02);
    chk("R7 active-high asserted", {7'd0, irq_pin}, 8'h01);
    tick(3'b000, 1, 0, 6'h31, 8'h00);
    chk("R7 active-high idle", {7'd0, irq_pin}, 8'h00);
    tick(3'b000, 0, 1, 6'h3A, 8'h00);
    chk("R7 back to active-low idle", {7'd0, irq_pin}, 8'h01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule